// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a periodic hardware timer. An up-counter advances once every N input clocks, where N is chosen by software from four prescale ratios. When a count step finds the counter equal to the compare register, the counter returns to zero and a match flag is latched. The flag, gated by an interrupt enable, drives a level interrupt. Loading a compare value C therefore gives an event every C+1 count steps.

The channel is built as either a 16-bit or a 32-bit variant, chosen by a parameter. The variant sets the counter width, the register stride, the bit positions inside the control/status register and the prescale encoding. Software reaches the channel through a single-cycle bus with byte addresses. Reads are combinational and writes take effect at the clock edge.

A start register sits at byte address 0 and holds one run bit per channel of a multi-channel timer unit. This instance stores and returns every bit of that register, but only its own bit lets its counter run.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter, the control/status register and the start register read 0, the compare register reads all ones, and `irq` is low.
- R2: The start register is at byte address 0. Control/status, counter and compare are at `CH_BASE` plus 0, 1 and 2 times the stride, where the stride is 2 bytes for the 16-bit variant and 4 bytes for the 32-bit variant. Any other address reads 0 and ignores writes.
- R3: A write to the start register stores all `NUM_CH` low data bits and reads them back. Only bit `CH_IDX` runs this channel. While that bit is 0 the counter holds its value.
- R4: While running, the counter takes one step every N clocks, with the first step N clocks after the run bit is written to 1. In the 16-bit variant, control bits 1:0 set N: 0 gives 8, 1 gives 32, 2 gives 128 and 3 gives 512. In the 32-bit variant, control bits 2:0 set N: 4 gives 8, 5 gives 32, 6 gives 128 and 7 gives 512, and any other code gives 8.
- R5: A count step that finds the counter equal to the compare value loads 0 into the counter and sets the match flag. The match flag is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant.
- R6: On a control/status write, each flag bit becomes its old value AND the written bit, so a written 0 clears the flag and a written 1 leaves it as it was. Every other bit takes the written value. If a match happens in the same cycle as the write, the match flag ends up set.
- R7: `irq` is high exactly when the match flag and the interrupt enable are both 1. The interrupt enable is bit 6 in the 16-bit variant and bit 5 in the 32-bit variant.
- R8: If the compare value is below the count, the counter climbs to all ones and then steps to 0 without setting the match flag. In the 32-bit variant that step sets bit 14, which clears the same way as the match flag.
- R9: A counter write loads the written value. It takes priority over a count step that falls in the same cycle.
- R10: In the 32-bit variant the counter and the compare register hold 32 bits. The control/status register holds 16 bits: bits 31:16 of a write are ignored and read back as 0. The value 0x01A4 enables the interrupt and selects N = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: match flag AND interrupt enable |

## Verification
A prescaler phase error shows up at the counter port within one prescale period, as a step one clock early or late. A wrong compare or wrap decision shows up at the moment the counter should reach zero: the counter holds a wrong value and the flag and `irq` are set when they should not be, or stay clear when they should be set. Because the read path is combinational, any corrupted register is visible the same cycle it is addressed. The reference model therefore compares the addressed register and `irq` on every clock. Bursts of back-to-back writes force a counter or flag write to land on the same edge as a count step or a match.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_START,
      SEL_CSR,
      SEL_CNT,
      SEL_CMP
   } reg_sel_t;

   localparam int CSR_W    = 16;
   localparam int PRE_W    = 9;
   localparam int SHIFT_W  = 4;

   // log2 of the prescale ratio, narrow variant: codes 0..3 -> 8,32,128,512
   function automatic logic [SHIFT_W-1:0] shift_narrow(input logic [1:0] code);
      logic [SHIFT_W-1:0] s;
      s = SHIFT_W'(3) + SHIFT_W'({code, 1'b0});
      return s;
   endfunction

   // log2 of the prescale ratio, wide variant: codes 4..7 -> 8..512, rest -> 8
   function automatic logic [SHIFT_W-1:0] shift_wide(input logic [2:0] code);
      logic [SHIFT_W-1:0] s;
      if (code[2]) s = SHIFT_W'(3) + SHIFT_W'({code[1:0], 1'b0});
      else         s = SHIFT_W'(3);
      return s;
   endfunction

endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
   parameter int PRE_W   = 9,
   parameter int SHIFT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_comb begin
      mask = ~({PRE_W{1'b1}} << shift);
      tick = run && ((pre_q & mask) == mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;
      else          pre_q <= '0;
   end
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cmp_q,
   output logic             match_evt,
   output logic             wrap_evt
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic step;
   logic hit;
   logic top;

   always_comb begin
      step      = tick && !cnt_wr;
      hit       = (cnt_q == cmp_q);
      top       = (cnt_q == ALL_ONES);
      match_evt = step && hit;
      wrap_evt  = step && !hit && top;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= wdata;
      end else if (tick) begin
         if (hit || top) cnt_q <= '0;
         else            cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cmp_q <= ALL_ONES;
      else if (cmp_wr) cmp_q <= wdata;
   end
endmodule

// File: rtl/cmt_csr.sv
`timescale 1ns/1ps
module cmt_csr #(
   parameter int               CSR_W     = 16,
   parameter logic [CSR_W-1:0] FLAG_MASK = 16'h0080
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CSR_W-1:0] wdata,
   input  logic [CSR_W-1:0] set_vec,
   output logic [CSR_W-1:0] csr_q
);
   for (genvar i = 0; i < CSR_W; i++) begin : g_bit
      if (FLAG_MASK[i]) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) csr_q[i] <= 1'b0;
            else        csr_q[i] <= (wr ? (csr_q[i] & wdata[i]) : csr_q[i]) | set_vec[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n) csr_q[i] <= 1'b0;
            else        csr_q[i] <= (wr ? wdata[i] : csr_q[i]) | set_vec[i];
         end
      end
   end
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel #(
   parameter int CNT_W   = 16,
   parameter int NUM_CH  = 3,
   parameter int CH_IDX  = 1,
   parameter int ADDR_W  = 8,
   parameter int CH_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);
   import cmt_pkg::*;

   localparam bit  WIDE     = (CNT_W == 32);
   localparam int  STRIDE   = WIDE ? 4 : 2;
   localparam int  FLAG_BIT = WIDE ? 15 : 7;
   localparam int  AUX_BIT  = 14;
   localparam int  IE_BIT   = WIDE ? 5 : 6;
   localparam logic [CSR_W-1:0] FLAG_MASK = WIDE ? 16'hC000 : 16'h0080;
   localparam logic [ADDR_W-1:0] A_START = '0;
   localparam logic [ADDR_W-1:0] A_CSR   = ADDR_W'(CH_BASE);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CH_BASE + STRIDE);
   localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(CH_BASE + 2 * STRIDE);

   // elaboration checks
   if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
      $error("cmt_channel: CNT_W must be 16 or 32");
   end
   if (CH_IDX < 0 || CH_IDX >= NUM_CH || NUM_CH > 16) begin : g_bad_ch
      $error("cmt_channel: channel index outside start register");
   end
   if (CH_BASE <= 0 || (CH_BASE % STRIDE) != 0 || CH_BASE + 2 * STRIDE >= (1 << ADDR_W)) begin : g_bad_base
      $error("cmt_channel: CH_BASE misaligned or outside address space");
   end

   reg_sel_t           reg_sel;
   logic               start_wr, csr_wr, cnt_wr, cmp_wr;
   logic [NUM_CH-1:0]  start_q;
   logic               run_bit;
   logic [SHIFT_W-1:0] shift;
   logic               tick;
   logic [CNT_W-1:0]   cnt_q, cmp_q;
   logic               match_evt, wrap_evt;
   logic [CSR_W-1:0]   csr_q, set_vec;
   logic               flag_bit;

   // address decode
   always_comb begin
      if      (bus_addr == A_START) reg_sel = SEL_START;
      else if (bus_addr == A_CSR)   reg_sel = SEL_CSR;
      else if (bus_addr == A_CNT)   reg_sel = SEL_CNT;
      else if (bus_addr == A_CMP)   reg_sel = SEL_CMP;
      else                          reg_sel = SEL_NONE;
      start_wr = bus_wr && (reg_sel == SEL_START);
      csr_wr   = bus_wr && (reg_sel == SEL_CSR);
      cnt_wr   = bus_wr && (reg_sel == SEL_CNT);
      cmp_wr   = bus_wr && (reg_sel == SEL_CMP);
   end

   // shared start register
   always_ff @(posedge clk) begin
      if (!rst_n)        start_q <= '0;
      else if (start_wr) start_q <= bus_wdata[NUM_CH-1:0];
   end
   assign run_bit = start_q[CH_IDX];

   // variant-specific prescale decode and flag sources
   if (WIDE) begin : g_wide
      always_comb begin
         shift            = shift_wide(csr_q[2:0]);
         set_vec          = '0;
         set_vec[FLAG_BIT] = match_evt;
         set_vec[AUX_BIT]  = wrap_evt;
      end
   end else begin : g_narrow
      always_comb begin
         shift            = shift_narrow(csr_q[1:0]);
         set_vec          = '0;
         set_vec[FLAG_BIT] = match_evt | (wrap_evt & 1'b0);
      end
   end

   cmt_prescaler #(.PRE_W(PRE_W), .SHIFT_W(SHIFT_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_bit),
      .shift (shift),
      .tick  (tick)
   );

   cmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_wr    (cnt_wr),
      .cmp_wr    (cmp_wr),
      .wdata     (bus_wdata),
      .cnt_q     (cnt_q),
      .cmp_q     (cmp_q),
      .match_evt (match_evt),
      .wrap_evt  (wrap_evt)
   );

   cmt_csr #(.CSR_W(CSR_W), .FLAG_MASK(FLAG_MASK)) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (csr_wr),
      .wdata   (bus_wdata[CSR_W-1:0]),
      .set_vec (set_vec),
      .csr_q   (csr_q)
   );

   assign flag_bit = csr_q[FLAG_BIT];
   assign irq      = flag_bit & csr_q[IE_BIT];

   // read mux
   always_comb begin
      unique case (reg_sel)
         SEL_START: bus_rdata = CNT_W'(start_q);
         SEL_CSR:   bus_rdata = CNT_W'(csr_q);
         SEL_CNT:   bus_rdata = cnt_q;
         SEL_CMP:   bus_rdata = cmp_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmt_channel_chk.sv
`timescale 1ns/1ps
module cmt_channel_chk #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_bit,
   input logic              tick,
   input logic              cnt_wr,
   input logic              start_wr,
   input logic              csr_wr,
   input logic              match_evt,
   input logic              flag_bit,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  wdata,
   input logic [NUM_CH-1:0] start_q
);
   p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_bit && !cnt_wr) |=> $stable(cnt_q));

   p_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !start_wr |=> $stable(start_q));

   p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   p_match_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> (cnt_q == '0));

   p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag_bit);

   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_bit && !csr_wr) |=> flag_bit);

   p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag_bit);

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wdata)));
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_bit   (run_bit),
   .tick      (tick),
   .cnt_wr    (cnt_wr),
   .start_wr  (start_wr),
   .csr_wr    (csr_wr),
   .match_evt (match_evt),
   .flag_bit  (flag_bit),
   .irq       (irq),
   .cnt_q     (cnt_q),
   .wdata     (bus_wdata),
   .start_q   (start_q)
);

// File: tb/tb_cmt_channel.sv
`timescale 1ns/1ps
module tb_cmt_channel;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // 16-bit instance
   logic [7:0]  addr = 8'h12;
   logic        wr = 1'b0;
   logic [15:0] wd = '0;
   logic [15:0] rd;
   logic        irq;
   logic [7:0]  mon = 8'h12;

   cmt_channel dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
      .bus_wdata(wd), .bus_rdata(rd), .irq(irq));

   // 32-bit instance
   logic [7:0]  w_addr = '0;
   logic        w_wr = 1'b0;
   logic [31:0] w_wd = '0;
   logic [31:0] w_rd;
   logic        w_irq;

   cmt_channel #(.CNT_W(32)) dut_w (
      .clk(clk), .rst_n(rst_n), .bus_addr(w_addr), .bus_wr(w_wr),
      .bus_wdata(w_wd), .bus_rdata(w_rd), .irq(w_irq));

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   bit    mdl_on = 1'b0;
   string phase = "R1";

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model of the 16-bit channel (CH_IDX=1, base 0x10)
   int m_start, m_pre, m_cnt, m_cmp, m_csr;

   function automatic int mdl_read(input logic [7:0] a);
      case (a)
         8'h00:   return m_start;
         8'h10:   return m_csr;
         8'h12:   return m_cnt;
         8'h14:   return m_cmp;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_start = 0; m_pre = 0; m_cnt = 0; m_cmp = 65535; m_csr = 0;
      end else begin
         int  div;
         bit  run, tk, hit;
         div = 8 << (2 * (m_csr & 3));
         run = ((m_start >> 1) & 1) == 1;
         tk  = run && ((m_pre % div) == div - 1);
         hit = 1'b0;
         if (wr && addr == 8'h12) m_cnt = int'(wd);
         else if (tk) begin
            if (m_cnt == m_cmp) begin m_cnt = 0; hit = 1'b1; end
            else if (m_cnt == 65535) m_cnt = 0;
            else m_cnt = m_cnt + 1;
         end
         if (wr && addr == 8'h14) m_cmp = int'(wd);
         if (wr && addr == 8'h10)
            m_csr = (int'(wd) & ~32'h80) | (m_csr & int'(wd) & 32'h80);
         if (hit) m_csr = m_csr | 32'h80;
         if (wr && addr == 8'h00) m_start = int'(wd) & 7;
         m_pre = run ? (m_pre + 1) % 512 : 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && mdl_on) begin
         int e;
         e = mdl_read(addr);
         chk(int'(rd) == e, {phase, " register readback"}, rd, e);
         chk(irq == (((m_csr >> 7) & (m_csr >> 6) & 1) == 1), {phase, " R7 irq"}, irq,
             (m_csr >> 7) & (m_csr >> 6) & 1);
      end
   end

   task automatic w16(input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1; addr = a; wd = d; wr = 1'b1;
      @(posedge clk); #1; wr = 1'b0; addr = mon;
   endtask

   task automatic burst16(input logic [7:0] a, input logic [15:0] d, input int n);
      @(posedge clk); #1; addr = a; wd = d; wr = 1'b1;
      repeat (n) @(posedge clk);
      #1; wr = 1'b0; addr = mon;
   endtask

   task automatic rd16(input logic [7:0] a, input int exp, input string tag);
      @(posedge clk); #1; addr = a;
      @(negedge clk); #1;
      chk(int'(rd) == exp, tag, rd, exp);
      addr = mon;
   endtask

   task automatic w32(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1; w_addr = a; w_wd = d; w_wr = 1'b1;
      @(posedge clk); #1; w_wr = 1'b0;
   endtask

   task automatic rd32(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1; w_addr = a;
      @(negedge clk); #1;
      chk(w_rd == exp, tag, w_rd, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1; rst_n = 1'b1;
      // R1 reset state
      rd16(8'h00, 0, "R1 start reset");
      rd16(8'h10, 0, "R1 csr reset");
      rd16(8'h12, 0, "R1 cnt reset");
      rd16(8'h14, 16'hFFFF, "R1 cmp reset");
      chk(irq == 1'b0, "R1 irq reset", irq, 0);
      mdl_on = 1'b1;
      // R2 unmapped addresses
      phase = "R2";
      rd16(8'h16, 0, "R2 unmapped 0x16");
      rd16(8'h11, 0, "R2 unmapped 0x11");
      w16(8'h20, 16'h1234);
      rd16(8'h20, 0, "R2 write to unmapped ignored");
      // R3 other channels' bits stored, own bit clear -> frozen
      phase = "R3";
      w16(8'h00, 16'h0005);
      rd16(8'h00, 5, "R3 start readback");
      repeat (40) @(posedge clk);
      rd16(8'h12, 0, "R3 frozen while own bit clear");
      // R4/R5/R7 periodic at /8, irq enabled
      phase = "R5";
      w16(8'h14, 16'd9);
      w16(8'h10, 16'h0040);
      w16(8'h00, 16'h0002);
      repeat (200) @(posedge clk);
      // R6 writing 1 keeps flag, then clear with /32 select
      phase = "R6";
      w16(8'h10, 16'h00C0);
      rd16(8'h10, 16'h00C0, "R6 flag kept on write of 1");
      w16(8'h10, 16'h0041);
      repeat (400) @(posedge clk);
      // R6 clear collides with match: cmp 0 at /8, back-to-back clears
      w16(8'h14, 16'd0);
      w16(8'h10, 16'h0040);
      burst16(8'h10, 16'h0040, 12);
      repeat (30) @(posedge clk);
      // R8 compare below count: climb through all ones
      phase = "R8";
      w16(8'h10, 16'h0040);
      w16(8'h14, 16'd20);
      w16(8'h12, 16'hFFF0);
      mon = 8'h10;
      repeat (300) @(posedge clk);
      // R9 counter write priority over count steps
      phase = "R9";
      mon = 8'h12;
      burst16(8'h12, 16'd5, 12);
      rd16(8'h12, 5, "R9 load wins over step");
      repeat (40) @(posedge clk);
      // R3 stop own channel, others untouched
      phase = "R3";
      w16(8'h00, 16'h0005);
      repeat (60) @(posedge clk);
      // R4 /512 and /128
      phase = "R4";
      w16(8'h10, 16'h0043);
      w16(8'h14, 16'd3);
      w16(8'h12, 16'd0);
      w16(8'h00, 16'h0002);
      repeat (5000) @(posedge clk);
      w16(8'h10, 16'h0042);
      repeat (1500) @(posedge clk);
      w16(8'h00, 16'h0000);
      mdl_on = 1'b0;

      // R10 32-bit variant: csr at 0x10, cnt at 0x14, cmp at 0x18
      w32(8'h10, 32'h0000_01A4);
      rd32(8'h10, 32'h0000_01A4, "R10 csr 0x01A4 readback");
      chk(w_irq == 1'b0, "R10 irq low before match", w_irq, 0);
      w32(8'h18, 32'd5);
      rd32(8'h18, 32'd5, "R10 cmp 32-bit");
      w32(8'h14, 32'hFFFF_FFFE);
      rd32(8'h14, 32'hFFFF_FFFE, "R10 cnt 32-bit");
      w32(8'h00, 32'h2);
      repeat (20) @(posedge clk);
      rd32(8'h10, 32'h0000_41A4, "R8 wide wrap flag bit14");
      chk(w_irq == 1'b0, "R7 wide no irq on wrap", w_irq, 0);
      repeat (60) @(posedge clk);
      rd32(8'h10, 32'h0000_C1A4, "R5 wide match flag bit15");
      chk(w_irq == 1'b1, "R7 wide irq", w_irq, 1);
      w32(8'h10, 32'h1234_3FA4);
      rd32(8'h10, 32'h0000_3FA4, "R10 R6 wide clear and upper bits ignored");
      chk(w_irq == 1'b0, "R7 wide irq after clear", w_irq, 0);
      w32(8'h00, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule